// File: doc/BRIEF.md
# Banked DRAM Command Sequencer

This block turns single-word read and write requests into the command stream of a synchronous DRAM with four banks. A request arrives with a valid/ready handshake, a read or write flag, a 23-bit word address and 16 bits of write data. The sequencer splits the address into row, bank and column fields and remembers, for every bank, whether a row is open and which one. A request to the row already open in its bank goes straight to a column command. A request to a different row first closes the bank, then opens the new row. A request to a closed bank only opens the row. Rows stay open after an access, so a series of accesses to one row costs a single activate.

Read data comes back on the DRAM data bus a fixed column latency after the read command. The sequencer samples it at that point and presents it with a one-cycle valid pulse, in request order. An internal interval counter raises a refresh request. The current access finishes, then every open bank is closed, then a refresh command is sent. While the refresh is waiting, no new request is accepted. Counters hold back the next command until the activate-to-column, precharge-to-activate and refresh-recovery gaps have passed.

Top module: `dram_cmd_seq`

## Requirements
- R1: Command codes on `cmd` are NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5. Address bits [22:11] are the row, [10:9] the bank and [8:0] the column. ACT carries the row on `cmd_addr[11:0]`. RD and WR carry the column on `cmd_addr[8:0]`. Every bank command carries its bank on `cmd_bank`. The kind of column command (RD or WR) matches the request.
- R2: A RD or WR is only sent to a bank whose open row equals the request's row.
- R3: A request whose row is already open in its bank produces its column command with no ACT or PRE in between.
- R4: A request to a closed bank produces exactly one ACT before its column command. A request to a bank holding a different row produces one PRE and then one ACT. PRE is only sent to an open bank, and ACT only to a closed one.
- R5: Gaps are counted in clock edges between command cycles. ACT to a column command on the same bank is at least T_RCD. PRE to ACT on the same bank is at least T_RP. REF to any later command is at least T_RFC.
- R6: The DRAM data bus is sampled CAS_LAT cycles after the RD command cycle. `rd_valid` pulses for one cycle one cycle later, with that word on `rd_data`. Words return in request order.
- R7: A WR command carries the request's write data on `cmd_wdata` in the same cycle.
- R8: REF is only sent when every bank is closed. Any open banks are precharged first.
- R9: A refresh request is raised every REF_INTERVAL cycles. Successive REF commands, and the first one after reset, are at most REF_INTERVAL plus a small bounded delay apart. No new request is raised while one is still pending.
- R10: While a refresh is pending, `req_ready` is low. A steady stream of requests therefore cannot hold off refresh.
- R11: During and right after reset, `cmd` is NOP, `rd_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address {row, bank, column} |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle pulse marking returned read data |
| rd_data | output | 16 | Returned read data |
| cmd | output | 3 | DRAM command code |
| cmd_bank | output | 2 | Bank of the current command |
| cmd_addr | output | 12 | Row for ACT, column for RD/WR, zero otherwise |
| cmd_wdata | output | 16 | Write data driven with WR |
| dram_rdata | input | 16 | Data bus from the DRAM |

## Verification
The bound checker watches rules that hold in every cycle:
- ACT goes only to a closed bank and PRE only to an open one.
- A column command never comes sooner than T_RCD after an activate.
- REF only happens with all banks closed.
- Ready stays low while a refresh is pending, and no refresh tick is lost.
- Each read-valid pulse sits exactly CAS_LAT plus one cycles after a RD command.

Other behaviour can only be shown by the bench's scenarios, which track a bank-state model and a shadow memory:
- that the right row is open when a column command is sent, and that hits, misses and conflicts produce the right number of ACT and PRE commands;
- that written data comes back from later reads, in order;
- that refresh keeps its interval under a continuous stream of requests.

// File: rtl/dram_seq_pkg.sv
// Shared types for the DRAM command sequencer.
// Assumes: command codes are fixed by the attached DRAM model / PHY.
package dram_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } dram_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_REFRESH = 2'd2
    } seq_state_e;

endpackage

// File: rtl/dram_bank_table.sv
// Per-bank open-row table.
// Holds an open flag and an open-row register for every bank. Answers
// whether the looked-up bank is open and whether its row matches. Also
// reports the lowest-numbered open bank, for closing banks before refresh.
// Assumes: set and clear never target the same bank in one cycle.
module dram_bank_table #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    localparam int BANKS = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] look_bank,
    input  logic [ROW_W-1:0]  look_row,
    input  logic              set_en,
    input  logic [BANK_W-1:0] set_bank,
    input  logic [ROW_W-1:0]  set_row,
    input  logic              clr_en,
    input  logic [BANK_W-1:0] clr_bank,
    output logic              look_open,
    output logic              look_hit,
    output logic [BANKS-1:0]  open_vec,
    output logic              any_open,
    output logic [BANK_W-1:0] first_open
);

    logic [BANKS-1:0][ROW_W-1:0] rows;

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic             open_r;
        logic [ROW_W-1:0] row_r;

        // Open or close one bank's entry on activate / precharge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_r <= 1'b0;
                row_r  <= '0;
            end else if (set_en && set_bank == BANK_W'(g)) begin
                open_r <= 1'b1;
                row_r  <= set_row;
            end else if (clr_en && clr_bank == BANK_W'(g)) begin
                open_r <= 1'b0;
            end
        end

        assign open_vec[g] = open_r;
        assign rows[g]     = row_r;
    end

    assign look_open = open_vec[look_bank];
    assign look_hit  = look_open && (rows[look_bank] == look_row);

    // Pick the lowest open bank for refresh-time closing.
    always_comb begin
        any_open   = 1'b0;
        first_open = '0;
        for (int i = BANKS - 1; i >= 0; i--) begin
            if (open_vec[i]) begin
                any_open   = 1'b1;
                first_open = BANK_W'(i);
            end
        end
    end

endmodule

// File: rtl/dram_gap_timer.sv
// Command gap timer.
// After a load of value N-1, done is low until N clock edges have passed
// since the load edge. The next command may then go out at that edge.
// Assumes: loads only happen while done is high.
module dram_gap_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    // Count down to zero after each load.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load_en)    cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/dram_refresh_timer.sv
// Refresh interval generator.
// Produces a tick every INTERVAL cycles and holds a pending flag until
// the sequencer acknowledges it by sending a refresh command.
// Assumes: INTERVAL is much longer than the worst refresh service delay.
module dram_refresh_timer #(
    parameter int INTERVAL = 780,
    localparam int CNT_W = $clog2(INTERVAL)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic tick,
    output logic pend
);

    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == CNT_W'(INTERVAL - 1));

    // Free-running interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // Pending flag: set on tick, cleared on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= 1'b0;
        else if (tick) pend <= 1'b1;
        else if (ack)  pend <= 1'b0;
    end

endmodule

// File: rtl/dram_read_return.sv
// Read data return path.
// A tag shift register follows each issued read. When a tag reaches
// CAS_LAT stages, the DRAM bus is captured and a valid pulse is produced.
// Assumes: CAS_LAT is 2 or 3; read_issued is high while a RD is on the bus.
module dram_read_return #(
    parameter int CAS_LAT = 2,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              read_issued,
    input  logic [DATA_W-1:0] bus_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic [CAS_LAT-1:0] tag_pipe;

    // Shift read tags toward the capture stage.
    always_ff @(posedge clk) begin
        if (!rst_n) tag_pipe <= '0;
        else        tag_pipe <= {tag_pipe[CAS_LAT-2:0], read_issued};
    end

    // Capture returned data when a tag arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= tag_pipe[CAS_LAT-1];
            if (tag_pipe[CAS_LAT-1]) rd_data <= bus_data;
        end
    end

endmodule

// File: rtl/dram_cmd_seq.sv
// Banked DRAM command sequencer (top).
// Accepts one request at a time. It opens the needed row (closing a
// conflicting one first) and issues the column command, leaving the row
// open. It services periodic refresh by closing all banks and sending REF.
// Assumes: ROW_W >= COL_W; the DRAM returns read data CAS_LAT cycles
// after RD.
module dram_cmd_seq
    import dram_seq_pkg::*;
#(
    parameter int ROW_W        = 12,
    parameter int BANK_W       = 2,
    parameter int COL_W        = 9,
    parameter int DATA_W       = 16,
    parameter int CAS_LAT      = 2,
    parameter int T_RCD        = 2,
    parameter int T_RP         = 2,
    parameter int T_RFC        = 6,
    parameter int REF_INTERVAL = 780,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W,
    localparam int BANKS  = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [2:0]        cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic [DATA_W-1:0] dram_rdata
);

    localparam int MAX_T = (T_RFC > T_RP) ? ((T_RFC > T_RCD) ? T_RFC : T_RCD)
                                          : ((T_RP > T_RCD) ? T_RP : T_RCD);
    localparam int GAP_W = $clog2(MAX_T + 1);

    seq_state_e        state, state_d;
    dram_cmd_e         cmd_q, cmd_d;
    logic [BANK_W-1:0] bank_q, bank_d;
    logic [ROW_W-1:0]  addr_q, addr_d;
    logic [DATA_W-1:0] wdata_q, wdata_d;

    logic              hold_write;
    logic [ROW_W-1:0]  hold_row;
    logic [BANK_W-1:0] hold_bank;
    logic [COL_W-1:0]  hold_col;
    logic [DATA_W-1:0] hold_wdata;

    logic              accept;
    logic              act_en, pre_en, ref_ack;
    logic [BANK_W-1:0] pre_bank;
    logic              gap_load;
    logic [GAP_W-1:0]  gap_val;
    logic              gap_done;
    logic              ref_tick, ref_pend;
    logic              bank_open, bank_hit, any_open;
    logic [BANK_W-1:0] first_open;
    logic [BANKS-1:0]  open_vec;

    assign req_ready = (state == ST_IDLE) && !ref_pend;
    assign accept    = req_valid && req_ready;

    dram_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_bank  (hold_bank),
        .look_row   (hold_row),
        .set_en     (act_en),
        .set_bank   (hold_bank),
        .set_row    (hold_row),
        .clr_en     (pre_en),
        .clr_bank   (pre_bank),
        .look_open  (bank_open),
        .look_hit   (bank_hit),
        .open_vec   (open_vec),
        .any_open   (any_open),
        .first_open (first_open)
    );

    dram_gap_timer #(.CNT_W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (gap_load),
        .load_val (gap_val),
        .done     (gap_done)
    );

    dram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_refresh (
        .clk   (clk),
        .rst_n (rst_n),
        .ack   (ref_ack),
        .tick  (ref_tick),
        .pend  (ref_pend)
    );

    dram_read_return #(.CAS_LAT(CAS_LAT), .DATA_W(DATA_W)) u_rdret (
        .clk         (clk),
        .rst_n       (rst_n),
        .read_issued (cmd_q == CMD_RD),
        .bus_data    (dram_rdata),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );

    // Latch the accepted request and split its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_write <= 1'b0;
            hold_row   <= '0;
            hold_bank  <= '0;
            hold_col   <= '0;
            hold_wdata <= '0;
        end else if (accept) begin
            hold_write <= req_write;
            hold_row   <= req_addr[ADDR_W-1 -: ROW_W];
            hold_bank  <= req_addr[COL_W +: BANK_W];
            hold_col   <= req_addr[COL_W-1:0];
            hold_wdata <= req_wdata;
        end
    end

    // Choose the next command and state.
    always_comb begin
        state_d  = state;
        cmd_d    = CMD_NOP;
        bank_d   = '0;
        addr_d   = '0;
        wdata_d  = '0;
        act_en   = 1'b0;
        pre_en   = 1'b0;
        pre_bank = hold_bank;
        ref_ack  = 1'b0;
        gap_load = 1'b0;
        gap_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (ref_pend)    state_d = ST_REFRESH;
                else if (accept) state_d = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (gap_done) begin
                    bank_d = hold_bank;
                    if (bank_hit) begin
                        cmd_d   = hold_write ? CMD_WR : CMD_RD;
                        addr_d  = ROW_W'(hold_col);
                        wdata_d = hold_write ? hold_wdata : '0;
                        state_d = ST_IDLE;
                    end else if (bank_open) begin
                        cmd_d    = CMD_PRE;
                        pre_en   = 1'b1;
                        gap_load = 1'b1;
                        gap_val  = GAP_W'(T_RP - 1);
                    end else begin
                        cmd_d    = CMD_ACT;
                        addr_d   = hold_row;
                        act_en   = 1'b1;
                        gap_load = 1'b1;
                        gap_val  = GAP_W'(T_RCD - 1);
                    end
                end
            end
            ST_REFRESH: begin
                if (gap_done) begin
                    if (any_open) begin
                        cmd_d    = CMD_PRE;
                        bank_d   = first_open;
                        pre_en   = 1'b1;
                        pre_bank = first_open;
                        gap_load = 1'b1;
                        gap_val  = GAP_W'(T_RP - 1);
                    end else begin
                        cmd_d    = CMD_REF;
                        ref_ack  = 1'b1;
                        gap_load = 1'b1;
                        gap_val  = GAP_W'(T_RFC - 1);
                        state_d  = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Register state and the command bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cmd_q   <= CMD_NOP;
            bank_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state   <= state_d;
            cmd_q   <= cmd_d;
            bank_q  <= bank_d;
            addr_q  <= addr_d;
            wdata_q <= wdata_d;
        end
    end

    assign cmd       = cmd_q;
    assign cmd_bank  = bank_q;
    assign cmd_addr  = addr_q;
    assign cmd_wdata = wdata_q;

endmodule

// File: rtl/dram_cmd_seq_chk.sv
// Protocol checker for dram_cmd_seq, bound to every instance.
// Watches the command bus, the bank table and the refresh flag.
module dram_cmd_seq_chk #(
    parameter int BANK_W  = 2,
    parameter int CAS_LAT = 2,
    parameter int T_RCD   = 2,
    localparam int BANKS  = 1 << BANK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cmd,
    input logic [BANK_W-1:0] cmd_bank,
    input logic              req_ready,
    input logic              rd_valid,
    input logic              ref_pend,
    input logic              ref_tick,
    input logic [BANKS-1:0]  open_vec
);

    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2,
                           C_WR  = 3'd3, C_PRE = 3'd4, C_REF = 3'd5;

    logic [BANKS-1:0]   prev_open;
    logic [CAS_LAT:0]   rd_hist;
    logic [7:0]         since_act;

    // Track bank state before the current command, read history and ACT age.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_open <= '0;
            rd_hist   <= '0;
            since_act <= 8'hFF;
        end else begin
            prev_open <= open_vec;
            rd_hist   <= {rd_hist[CAS_LAT-1:0], cmd == C_RD};
            if (cmd == C_ACT)          since_act <= 8'd1;
            else if (since_act != 8'hFF) since_act <= since_act + 8'd1;
        end
    end

    assert_reset_idle_R11: assert property (@(posedge clk)
        !rst_n |=> (cmd == C_NOP && !rd_valid));

    assert_act_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == C_ACT) |-> !prev_open[cmd_bank]);

    assert_pre_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == C_PRE) |-> prev_open[cmd_bank]);

    assert_col_after_rcd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == C_RD || cmd == C_WR) |-> (since_act >= 8'(T_RCD)));

    assert_col_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == C_RD || cmd == C_WR) |-> open_vec[cmd_bank]);

    assert_ref_all_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == C_REF) |-> (prev_open == '0));

    assert_ready_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pend |-> !req_ready);

    assert_no_lost_refresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |-> !ref_pend);

    assert_rd_valid_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == rd_hist[CAS_LAT]);

endmodule

bind dram_cmd_seq dram_cmd_seq_chk #(
    .BANK_W  (BANK_W),
    .CAS_LAT (CAS_LAT),
    .T_RCD   (T_RCD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .cmd_bank  (cmd_bank),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .ref_pend  (ref_pend),
    .ref_tick  (ref_tick),
    .open_vec  (open_vec)
);

// File: tb/dram_cmd_seq_tb.sv
// Bench for dram_cmd_seq: DRAM behavioural model with protocol checks,
// shadow memory for end-to-end data, random plus directed requests.
module dram_cmd_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CL      = 3;
    localparam int T_RCD   = 2;
    localparam int T_RP    = 2;
    localparam int T_RFC   = 6;
    localparam int REF_INT = 780;
    localparam int REF_SLACK = 5 * T_RP + T_RCD + T_RFC + 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [22:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [2:0]  cmd;
    logic [1:0]  cmd_bank;
    logic [11:0] cmd_addr;
    logic [15:0] cmd_wdata;
    logic [15:0] dram_rdata = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dram_cmd_seq #(
        .CAS_LAT (CL), .T_RCD (T_RCD), .T_RP (T_RP),
        .T_RFC (T_RFC), .REF_INTERVAL (REF_INT)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_write (req_write), .req_addr (req_addr), .req_wdata (req_wdata),
        .rd_valid (rd_valid), .rd_data (rd_data),
        .cmd (cmd), .cmd_bank (cmd_bank), .cmd_addr (cmd_addr),
        .cmd_wdata (cmd_wdata), .dram_rdata (dram_rdata)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    bit model_on = 1'b0;

    logic [15:0] shadow [int];
    logic [15:0] mem    [int];
    logic [15:0] exp_q  [$];
    logic [39:0] rq     [$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] init_word(input logic [22:0] a);
        return a[15:0] ^ {9'b0, a[22:16]};
    endfunction

    function automatic logic [22:0] mk_addr(input logic [11:0] row,
                                            input logic [1:0] bank,
                                            input logic [8:0] col);
        return {row, bank, col};
    endfunction

    // DRAM model state
    bit          m_open [4];
    logic [11:0] m_row  [4];
    bit          s_open [4];
    logic [11:0] s_row  [4];
    int          last_act [4];
    int          last_pre [4];
    int          last_ref_cmd = -1000;
    int          ref_anchor = 0;
    int          ref_count = 0;
    int          n_act = 0, n_pre = 0;
    int          cyc = 0;
    bit          st_v [CL+1];
    logic [15:0] st_d [CL+1];

    // DRAM model: observes the command bus at each falling edge.
    initial begin
        for (int i = 0; i < 4; i++) begin
            m_open[i] = 0; s_open[i] = 0; m_row[i] = '0; s_row[i] = '0;
            last_act[i] = -1000; last_pre[i] = -1000;
        end
        for (int k = 0; k <= CL; k++) begin st_v[k] = 0; st_d[k] = '0; end
        wait (model_on);
        forever begin
            @(negedge clk);
            cyc++;
            for (int k = CL; k > 0; k--) begin st_v[k] = st_v[k-1]; st_d[k] = st_d[k-1]; end
            st_v[0] = 0;
            if (cmd != 3'd0)
                check(cyc - last_ref_cmd >= T_RFC, "R5", "REF recovery gap", cyc - last_ref_cmd, T_RFC);
            case (cmd)
                3'd1: begin
                    check(!m_open[cmd_bank], "R4", "ACT to open bank", cmd_bank, 0);
                    check(cyc - last_pre[cmd_bank] >= T_RP, "R5", "PRE->ACT gap",
                          cyc - last_pre[cmd_bank], T_RP);
                    m_open[cmd_bank] = 1; m_row[cmd_bank] = cmd_addr;
                    last_act[cmd_bank] = cyc; n_act++;
                end
                3'd4: begin
                    check(m_open[cmd_bank], "R4", "PRE to closed bank", cmd_bank, 1);
                    m_open[cmd_bank] = 0; last_pre[cmd_bank] = cyc; n_pre++;
                end
                3'd5: begin
                    check(!(m_open[0] || m_open[1] || m_open[2] || m_open[3]), "R8",
                          "REF with open bank", {m_open[3], m_open[2], m_open[1], m_open[0]}, 0);
                    check(cyc - ref_anchor <= REF_INT + REF_SLACK, "R9", "refresh spacing",
                          cyc - ref_anchor, REF_INT + REF_SLACK);
                    ref_anchor = cyc; last_ref_cmd = cyc; ref_count++;
                    for (int i = 0; i < 4; i++) begin s_open[i] = m_open[i]; s_row[i] = m_row[i]; end
                    n_act = 0; n_pre = 0;
                end
                3'd2, 3'd3: begin
                    if (rq.size() == 0) begin
                        check(0, "R1", "column command without request", cmd, 0);
                    end else begin
                        logic [39:0] e;
                        logic [22:0] a;
                        logic [11:0] rrow;
                        logic [1:0]  rb;
                        bit hit, conf;
                        e = rq.pop_front();
                        a = e[38:16]; rrow = a[22:11]; rb = a[10:9];
                        check(cmd == (e[39] ? 3'd3 : 3'd2), "R1", "column kind", cmd, e[39] ? 3 : 2);
                        check(cmd_bank == rb, "R1", "column bank", cmd_bank, rb);
                        check(cmd_addr[8:0] == a[8:0], "R1", "column address", cmd_addr[8:0], a[8:0]);
                        check(m_open[rb] && m_row[rb] == rrow, "R2", "open row at column",
                              m_row[rb], rrow);
                        check(cyc - last_act[rb] >= T_RCD, "R5", "ACT->column gap",
                              cyc - last_act[rb], T_RCD);
                        hit  = s_open[rb] && s_row[rb] == rrow;
                        conf = s_open[rb] && s_row[rb] != rrow;
                        if (hit)
                            check(n_act == 0 && n_pre == 0, "R3", "hit issued ACT/PRE",
                                  n_act * 16 + n_pre, 0);
                        else
                            check(n_act == 1 && n_pre == (conf ? 1 : 0), "R4", "miss ACT/PRE count",
                                  n_act * 16 + n_pre, conf ? 17 : 16);
                        if (cmd == 3'd3) begin
                            check(cmd_wdata == e[15:0], "R7", "write data", cmd_wdata, e[15:0]);
                            mem[int'(a)] = cmd_wdata;
                        end else begin
                            st_v[0] = 1;
                            st_d[0] = mem.exists(int'(a)) ? mem[int'(a)] : init_word(a);
                        end
                        for (int i = 0; i < 4; i++) begin s_open[i] = m_open[i]; s_row[i] = m_row[i]; end
                        n_act = 0; n_pre = 0;
                    end
                end
                default: ;
            endcase
            dram_rdata = st_v[CL] ? st_d[CL] : 16'h0;
            if (rd_valid) begin
                if (exp_q.size() == 0) check(0, "R6", "unexpected read valid", rd_data, 0);
                else begin
                    logic [15:0] x;
                    x = exp_q.pop_front();
                    check(rd_data == x, "R6", "read data", rd_data, x);
                end
            end
        end
    end

    // Drive one request at a falling edge; returns after acceptance.
    task automatic send(input bit wr, input logic [22:0] a, input logic [15:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        rq.push_back({wr, a, d});
        if (wr) shadow[int'(a)] = d;
        else exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : init_word(a));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 400 && (exp_q.size() != 0 || rq.size() != 0); i++) @(negedge clk);
        repeat (CL + 4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int ref_before;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11: reset state
        check(cmd == 3'd0, "R11", "cmd in reset", cmd, 0);
        check(rd_valid == 1'b0, "R11", "rd_valid in reset", rd_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);
        check(cmd == 3'd0 && req_ready == 1'b1, "R11", "idle after reset",
              {cmd, req_ready}, 1);

        // Directed: closed bank, hits, conflict, extreme row/column
        send(1, mk_addr(12'd5, 2'd1, 9'd0), 16'hA001);
        send(1, mk_addr(12'd5, 2'd1, 9'd511), 16'hA002);
        send(0, mk_addr(12'd5, 2'd1, 9'd0), 16'h0);
        send(0, mk_addr(12'd5, 2'd1, 9'd511), 16'h0);
        send(0, mk_addr(12'd6, 2'd1, 9'd7), 16'h0);
        send(1, mk_addr(12'd4095, 2'd3, 9'd511), 16'hFFFF);
        send(0, mk_addr(12'd4095, 2'd3, 9'd511), 16'h0);
        send(0, mk_addr(12'd5, 2'd1, 9'd511), 16'h0);
        drain();

        // Random mix with row locality to produce hits and conflicts
        for (int n = 0; n < 600; n++) begin
            logic [11:0] rows [4];
            logic [1:0]  b;
            logic [8:0]  c;
            rows[0] = 12'd0; rows[1] = 12'd1; rows[2] = 12'd2; rows[3] = 12'd4095;
            b = 2'($urandom % 4);
            c = 9'($urandom % 8) + (($urandom % 4 == 0) ? 9'd504 : 9'd0);
            send(1'($urandom % 2), mk_addr(rows[$urandom % 4], b, c), 16'($urandom));
            if ($urandom % 5 == 0) repeat ($urandom % 4) @(negedge clk);
        end
        drain();

        // R10: continuous hits on one row must not hold off refresh
        ref_before = ref_count;
        for (int n = 0; n < 500; n++)
            send(1'(n % 2), mk_addr(12'd9, 2'd2, 9'(n % 16)), 16'(n));
        drain();
        check(ref_count > ref_before, "R10", "refresh during request stream",
              ref_count - ref_before, 1);

        // R9: idle refresh keeps running
        ref_before = ref_count;
        repeat (2 * REF_INT + REF_SLACK) @(negedge clk);
        check(ref_count >= ref_before + 2, "R9", "idle refresh count",
              ref_count - ref_before, 2);
        check(exp_q.size() == 0, "R6", "reads all returned", exp_q.size(), 0);
        finish_run();
    end

endmodule